// File: doc/BRIEF.md
# Receive Descriptor Ring Poll Scheduler

This block tells a buffer manager when to read the next receive descriptor from its ring in memory. With no software involvement, a down-counting poll timer raises a fetch request each time it reaches zero. Software can bring the next fetch forward by writing a one to the demand bit of a small control register. That bit stays set until the buffer manager acknowledges the fetch it caused. Writing a zero to it does nothing.

Requests are made only while the receive engine is running and not suspended. A demand written while the engine is halted is kept, and it is served as soon as the engine resumes. Each fetch holds its request until the buffer manager acknowledges it. Every acknowledged fetch reloads the poll timer from the programmed interval, whether the timer or the demand bit caused it. A demand and a timer expiry that are both pending are served by a single fetch.

Top module: `ring_poll_sched`

## Requirements
- R1: After reset, fetch_req is low, ctrl_rdata is all zero, and the poll counter holds zero, so the first fetch is requested in the first cycle the engine is active.
- R2: A write (wr_en high) with wr_data bit DMD_BIT (default 3) at 1 sets the demand bit. The bit reads back as 1 at ctrl_rdata[DMD_BIT] in the next cycle.
- R3: A write with wr_data bit DMD_BIT at 0 leaves the demand bit unchanged, whatever the other data bits hold.
- R4: When the demand bit is set, the engine is active (run_en high, suspend low) and no request is outstanding, fetch_req goes high in the next cycle, without waiting for the counter.
- R5: With no demand pending and the engine active throughout, fetch_req goes high N+1 cycles after the acknowledge cycle, where N is poll_interval at the acknowledge.
- R6: Once high, fetch_req stays high until a cycle with fetch_ack high, and it is low in the cycle after that acknowledge. fetch_ack with no request outstanding is ignored.
- R7: The demand bit clears only in an acknowledge cycle. A demand write in that same cycle leaves the bit set.
- R8: A pending demand and an expired counter produce a single request. Its acknowledge clears the demand bit and reloads the counter.
- R9: While run_en is low or suspend is high, no new request is raised and the counter does not move. A demand bit set during that time is kept.
- R10: Every bit of ctrl_rdata other than DMD_BIT reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control register write data |
| poll_interval | input | CNT_W | Counter reload value, in cycles |
| run_en | input | 1 | Receive engine running |
| suspend | input | 1 | Receive engine suspended |
| fetch_ack | input | 1 | Buffer manager has done the ring access |
| fetch_req | output | 1 | Request to fetch the next receive descriptor |
| ctrl_rdata | output | DATA_W | Control register read value |

## Verification
A demand bit that is lost or stuck shows at ctrl_rdata one cycle after the write or the acknowledge that should have changed it. It also shows at fetch_req one cycle later, as a missing or repeated request. A counter that reloads wrongly or moves while the engine is halted moves the next timer request earlier or later. That shows within N+1 cycles of an acknowledge, so the bench keeps intervals small and measures the gap from each acknowledge to the next request. A request state that drops early or latches twice shows at fetch_req in the cycle after the acknowledge.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_st_e;
endpackage

// File: rtl/rps_poll_timer.sv
module rps_poll_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reload) begin
            s_d.cnt = interval;
        end else if (tick && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expired = (s_q.cnt == '0);
endmodule

// File: rtl/rps_demand_flag.sv
module rps_demand_flag #(
    parameter int DATA_W  = 16,
    parameter int DMD_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    output logic              pending,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic dmd;
    } flag_s;

    flag_s s_d, s_q;
    logic  set_hit;
    logic  unused_wr_bits;

    assign set_hit        = wr_en && wr_data[DMD_BIT];
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        s_d = s_q;
        if (clear)   s_d.dmd = 1'b0;
        if (set_hit) s_d.dmd = 1'b1;  // a fresh write outranks the clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending = s_q.dmd;
    assign rdata   = DATA_W'(s_q.dmd) << DMD_BIT;
endmodule

// File: rtl/ring_poll_sched.sv
module ring_poll_sched #(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    parameter int DMD_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  poll_interval,
    input  logic              run_en,
    input  logic              suspend,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [DATA_W-1:0] ctrl_rdata
);
    import rps_pkg::*;

    typedef struct packed {
        req_st_e st;
    } sched_s;

    sched_s s_d, s_q;
    logic   active;
    logic   fire;
    logic   pending;
    logic   expired;

    assign active = run_en && !suspend;
    assign fire   = (s_q.st == REQ_WAIT) && fetch_ack;

    rps_demand_flag #(
        .DATA_W (DATA_W),
        .DMD_BIT(DMD_BIT)
    ) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .clear  (fire),
        .pending(pending),
        .rdata  (ctrl_rdata)
    );

    rps_poll_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (fire),
        .tick    (active && (s_q.st == REQ_IDLE)),
        .interval(poll_interval),
        .expired (expired)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            REQ_IDLE: if (active && (pending || expired)) s_d.st = REQ_WAIT;
            REQ_WAIT: if (fetch_ack)                      s_d.st = REQ_IDLE;
            default:                                      s_d.st = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: REQ_IDLE};
        else        s_q <= s_d;
    end

    assign fetch_req = (s_q.st == REQ_WAIT);
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int DATA_W  = 16,
    parameter int DMD_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              run_en,
    input logic              suspend,
    input logic              fetch_ack,
    input logic              fetch_req,
    input logic [DATA_W-1:0] ctrl_rdata
);
    localparam logic [DATA_W-1:0] RESV_MASK = ~(DATA_W'(1) << DMD_BIT);

    logic unused_chk_bits;
    assign unused_chk_bits = ^wr_data;

    assert_dmd_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[DMD_BIT] |=> ctrl_rdata[DMD_BIT]);

    assert_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[DMD_BIT] && !(wr_en && wr_data[DMD_BIT]) |=> !ctrl_rdata[DMD_BIT]);

    assert_demand_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req && ctrl_rdata[DMD_BIT] && run_en && !suspend |=> fetch_req);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> fetch_req);

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_ack |=> !fetch_req);

    assert_dmd_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[DMD_BIT] && !(fetch_req && fetch_ack) |=> ctrl_rdata[DMD_BIT]);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req && !(run_en && !suspend) |=> !fetch_req);

    always @(posedge clk) begin
        if (rst_n) begin
            assert_resv_zero_R10: assert ((ctrl_rdata & RESV_MASK) == '0);
        end
    end
endmodule

bind ring_poll_sched rps_checker #(
    .DATA_W (DATA_W),
    .DMD_BIT(DMD_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .run_en    (run_en),
    .suspend   (suspend),
    .fetch_ack (fetch_ack),
    .fetch_req (fetch_req),
    .ctrl_rdata(ctrl_rdata)
);

// File: tb/sim_ring_poll_sched.sv
`timescale 1ns/1ps
module sim_ring_poll_sched;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = 8;
    localparam int DMD_BIT    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [CNT_W-1:0]  poll_interval = CNT_W'(3);
    logic              run_en = 1'b0;
    logic              suspend = 1'b0;
    logic              fetch_ack = 1'b0;
    logic              fetch_req;
    logic [DATA_W-1:0] ctrl_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state, built from the requirements
    bit             m_req = 1'b0;
    bit             m_dmd = 1'b0;
    int unsigned    m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_poll_sched #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .DMD_BIT(DMD_BIT)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .poll_interval(poll_interval),
        .run_en       (run_en),
        .suspend      (suspend),
        .fetch_ack    (fetch_ack),
        .fetch_req    (fetch_req),
        .ctrl_rdata   (ctrl_rdata)
    );

    function automatic logic [DATA_W-1:0] exp_rdata(bit dmd);
        return dmd ? (DATA_W'(1) << DMD_BIT) : '0;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // advance one cycle, update the reference, compare away from the edge
    task automatic step(string tag);
        bit fire, act, set;
        bit n_req, n_dmd;
        int unsigned n_cnt;
        @(posedge clk);
        fire = m_req && fetch_ack;
        act  = run_en && !suspend;
        set  = wr_en && wr_data[DMD_BIT];
        n_cnt = m_cnt;
        if (fire) begin
            n_req = 1'b0;
            n_cnt = poll_interval;
        end else if (m_req) begin
            n_req = 1'b1;
        end else begin
            n_req = act && (m_dmd || m_cnt == 0);
            if (act && m_cnt != 0) n_cnt = m_cnt - 1;
        end
        n_dmd = (m_dmd && !fire) || set;
        m_req = n_req;
        m_dmd = n_dmd;
        m_cnt = n_cnt;
        #1;
        check(fetch_req === m_req, {tag, " fetch_req"}, fetch_req, m_req);
        check(ctrl_rdata === exp_rdata(m_dmd), {tag, " ctrl_rdata"}, ctrl_rdata, exp_rdata(m_dmd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int gap;
        void'($urandom(32'd1947));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check(fetch_req === 1'b0, "R1 fetch_req", fetch_req, 0);
        check(ctrl_rdata === '0, "R1 ctrl_rdata", ctrl_rdata, 0);

        // R2 with reserved bits set in the data, engine halted
        wr_en = 1'b1; wr_data = 16'hF008;
        step("R2");
        wr_en = 1'b0; wr_data = '0;
        check(ctrl_rdata === 16'h0008, "R2 R10 readback", ctrl_rdata, 16'h0008);

        // R9: halted, demand kept, no request
        repeat (5) step("R9");
        check(fetch_req === 1'b0, "R9 halted req", fetch_req, 0);

        // R3: write with demand bit zero changes nothing
        wr_en = 1'b1; wr_data = 16'hFFF7;
        step("R3");
        wr_en = 1'b0; wr_data = '0;
        check(ctrl_rdata[DMD_BIT] === 1'b1, "R3 demand kept", ctrl_rdata[DMD_BIT], 1);

        // R8: demand plus expired counter -> one request
        run_en = 1'b1;
        step("R8");
        check(fetch_req === 1'b1, "R8 req", fetch_req, 1);
        fetch_ack = 1'b1;
        step("R8");
        fetch_ack = 1'b0;
        check(fetch_req === 1'b0, "R8 single req", fetch_req, 0);
        check(ctrl_rdata === '0, "R8 demand cleared", ctrl_rdata, 0);

        // R5: timer gap of N+1 after the acknowledge (N = 3)
        gap = 0;
        for (int k = 1; k <= 20; k++) begin
            step("R5");
            if (fetch_req && gap == 0) gap = k;
        end
        check(gap == 4, "R5 poll gap", gap, 4);

        // R6: request holds without acknowledge
        repeat (6) step("R6");
        check(fetch_req === 1'b1, "R6 hold", fetch_req, 1);

        // R7: demand write in the acknowledge cycle survives
        fetch_ack = 1'b1; wr_en = 1'b1; wr_data = 16'h0008;
        step("R7");
        fetch_ack = 1'b0; wr_en = 1'b0; wr_data = '0;
        check(fetch_req === 1'b0, "R6 drop after ack", fetch_req, 0);
        check(ctrl_rdata[DMD_BIT] === 1'b1, "R7 demand survives", ctrl_rdata[DMD_BIT], 1);

        // R4: demand served at once, before the counter runs out
        poll_interval = CNT_W'(40);
        step("R4");
        check(fetch_req === 1'b1, "R4 demand req", fetch_req, 1);
        fetch_ack = 1'b1;
        step("R4");
        fetch_ack = 1'b0;

        // R9: suspend freezes the counter; R5 gap then counts only active cycles
        poll_interval = CNT_W'(2);
        suspend = 1'b1;
        repeat (20) step("R9");
        check(fetch_req === 1'b0, "R9 suspended", fetch_req, 0);
        suspend = 1'b0;
        gap = 0;
        for (int k = 1; k <= 60; k++) begin
            step("R9");
            if (fetch_req && gap == 0) gap = k;
        end
        check(gap == 41, "R9 frozen counter gap", gap, 41);
        fetch_ack = 1'b1;
        step("R6");
        fetch_ack = 1'b0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en     = ($urandom % 10) == 0;
            wr_data   = DATA_W'($urandom);
            fetch_ack = ($urandom % 5) < 2;
            run_en    = ($urandom % 10) != 0;
            suspend   = ($urandom % 10) == 0;
            if (($urandom % 50) == 0) poll_interval = CNT_W'($urandom % 8);
            step("rand");
        end
        report();
    end
endmodule